// File: doc/BRIEF.md
# PR4 Decision-Directed Timing Error Detector

This block produces one signed phase-error word per accepted sample for the read-side timing recovery loop of a partial-response class-4 channel. Each accepted sample arrives with its ternary decision. The block keeps a three-sample window and evaluates its middle entry. If the middle decision is zero, the middle sample should sit at ground. Its value, signed by the trend of the decisions on either side, becomes the error. If the middle and newest decisions are "ones" of the same polarity, the error is the difference of their magnitudes.

While the loop is acquiring, the error is passed on at full gain. A guard against hang-up forces a fixed-size kick when the error keeps one sign for too long. A strobe marks the point where the sync field count is reached. From then on the block is in tracking and divides the error by 6 or by 10, chosen by a select bit. The lower gain narrows the loop bandwidth and improves noise immunity. The result is registered. A charge-pump model takes up and down pulses plus a magnitude word, weighted by a 7-bit damping code.

Top module: `pr4_timing_err_det`

## Requirements
- R1: While reset is held, and in the first cycle after it, err_valid, err, pump_up, pump_dn and pump_mag are all zero, and the block is in acquisition mode.
- R2: A sample is accepted on a rising edge with in_valid high. err_valid rises on the edge of an accepted sample only if two earlier samples were accepted since reset; err_valid and err then hold for exactly that one cycle. Cycles with in_valid low leave the sample window unchanged and give err_valid=0, err=0.
- R3: Decisions are encoded 2'b00 zero, 2'b01 plus one and 2'b11 minus one; 2'b10 counts as zero. Let k be the newest sample. When the middle decision d[k-1] is zero, the raw error is x[k-1] if d[k] > d[k-2], -x[k-1] if d[k] < d[k-2], and 0 if they are equal.
- R4: When d[k-1] is nonzero and d[k] equals d[k-1], the raw error is |x[k]| - |x[k-1]|. With any other nonzero middle decision the raw error is 0.
- R5: Once sfc is high on a rising edge, tracking mode stays set until reset. The sample accepted on that same edge is still processed in acquisition mode.
- R6: In tracking mode err equals the raw error divided by 6 (gain_sel=0) or by 10 (gain_sel=1), truncated toward zero. gain_sel is sampled with the sample.
- R7: In acquisition mode err equals the raw error unscaled, unless R8 applies.
- R8: In acquisition mode, a nonzero raw error that makes 16 consecutive raw errors of one sign is replaced by +32 or -32 with that sign, and the run count restarts. A zero raw error ends the run. A sign change starts a new run of length one.
- R9: pump_up is 1 exactly when err_valid and err>0. pump_dn is 1 exactly when err_valid and err<0. pump_mag equals floor(|err| * damp_code / 64) when valid, else 0.
- R10: In tracking mode the forced error of R8 never occurs, and the run count is held at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample and decision are present this cycle |
| sample | input | 8 | Two's-complement sample value |
| decision | input | 2 | Ternary decision for the sample |
| sfc | input | 1 | Sync field count reached strobe |
| gain_sel | input | 1 | Tracking gain divisor select: 0 gives /6, 1 gives /10 |
| damp_code | input | 7 | Damping weight for the charge-pump magnitude |
| err_valid | output | 1 | err holds a new phase error |
| err | output | 9 | Signed phase error |
| pump_up | output | 1 | Positive correction pulse |
| pump_dn | output | 1 | Negative correction pulse |
| pump_mag | output | 9 | Charge-pump magnitude |

## Verification
The bench sweeps every sample value through the zero-middle rule at both gain settings. A divider built on a reciprocal that is too short, or that rounds the wrong way for negative values, gives quotients off by one near multiples of 6 or 10. Directed runs of 15 and 16 same-sign errors, in both signs, with a zero inserted, expose an off-by-one guard or one that ignores run breaks. A strobe that is applied on the same edge as a sample, and idle gaps inside the window, catch early mode switching and a history that shifts on invalid cycles. Long pseudo-random streams at random damping codes exercise priority between the two error rules and the pump magnitude arithmetic.

// File: rtl/ted_pkg.sv
package ted_pkg;

  typedef enum logic [1:0] {
    DEC_ZERO = 2'b00,
    DEC_POS  = 2'b01,
    DEC_RSV  = 2'b10,
    DEC_NEG  = 2'b11
  } ted_dec_e;

  // Ternary decision to a signed level; the spare code counts as zero.
  function automatic int dec_level(input logic [1:0] d);
    case (d)
      DEC_POS: return 1;
      DEC_NEG: return -1;
      default: return 0;
    endcase
  endfunction

  function automatic int mag_of(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // Raw phase error of the middle entry of a three-sample window.
  function automatic int phase_err(input int x_new, input int lv_new,
                                   input int x_mid, input int lv_mid,
                                   input int lv_old);
    if (lv_mid == 0) begin
      if (lv_new > lv_old)      return x_mid;
      else if (lv_new < lv_old) return -x_mid;
      else                      return 0;
    end
    if (lv_new == lv_mid) return mag_of(x_new) - mag_of(x_mid);
    return 0;
  endfunction

  // Rounded-up reciprocal, so that truncation of the product is exact.
  function automatic int recip_const(input int frac, input int divisor);
    return ((1 << frac) + divisor - 1) / divisor;
  endfunction

endpackage

// File: rtl/ted_window.sv
module ted_window #(
  parameter int W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic signed [W-1:0] sample,
  input  logic [1:0]          decision,
  output logic signed [W-1:0] x_mid,
  output logic [1:0]          d_mid,
  output logic [1:0]          d_old,
  output logic                win_ready
);

  localparam int CNT_W = 2;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(2);

  logic [CNT_W-1:0] fill_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_mid    <= '0;
      d_mid    <= 2'b00;
      d_old    <= 2'b00;
      fill_cnt <= '0;
    end else if (in_valid) begin
      x_mid <= sample;
      d_mid <= decision;
      d_old <= d_mid;
      if (fill_cnt != FULL) fill_cnt <= fill_cnt + 1'b1;
    end
  end

  assign win_ready = (fill_cnt == FULL);

endmodule

// File: rtl/ted_err_form.sv
module ted_err_form
  import ted_pkg::*;
#(
  parameter int W = 8
) (
  input  logic signed [W-1:0] x_new,
  input  logic [1:0]          d_new,
  input  logic signed [W-1:0] x_mid,
  input  logic [1:0]          d_mid,
  input  logic [1:0]          d_old,
  output logic signed [W:0]   raw
);

  int raw_i;

  always_comb begin
    raw_i = phase_err(int'(x_new), dec_level(d_new),
                      int'(x_mid), dec_level(d_mid), dec_level(d_old));
    raw   = (W+1)'(raw_i);
  end

endmodule

// File: rtl/ted_gain_scale.sv
module ted_gain_scale
  import ted_pkg::*;
#(
  parameter int W      = 8,
  parameter int FRAC   = 12,
  parameter int DIV_LO = 6,
  parameter int DIV_HI = 10
) (
  input  logic signed [W:0] raw,
  input  logic              gain_sel,
  output logic signed [W:0] scaled
);

  localparam int NSEL = 2;
  localparam int PW   = W + 1 + FRAC;

  logic [W:0] raw_mag;
  logic [W:0] quot [NSEL];

  assign raw_mag = raw[W] ? (W+1)'(-raw) : raw;

  for (genvar gi = 0; gi < NSEL; gi++) begin : g_div
    localparam int DV = (gi == 0) ? DIV_LO : DIV_HI;
    localparam logic [FRAC-1:0] MK = FRAC'(recip_const(FRAC, DV));
    logic [PW-1:0] prod;
    assign prod     = {{FRAC{1'b0}}, raw_mag} * {{(W+1){1'b0}}, MK};
    assign quot[gi] = prod[FRAC +: W+1];
  end

  always_comb begin
    logic [W:0] q_sel;
    q_sel  = gain_sel ? quot[1] : quot[0];
    scaled = raw[W] ? -$signed(q_sel) : $signed(q_sel);
  end

endmodule

// File: rtl/ted_hang_guard.sv
module ted_hang_guard #(
  parameter int HANG_N = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  logic clr,
  input  logic raw_pos,
  input  logic raw_neg,
  output logic fire
);

  localparam int CW = $clog2(HANG_N + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HANG_N);

  logic [CW-1:0] run_len;
  logic          run_neg;
  logic [CW-1:0] run_nxt;
  logic          nonzero;
  logic          same_sign;

  assign nonzero   = raw_pos | raw_neg;
  assign same_sign = (run_len != '0) && (run_neg == raw_neg);
  assign run_nxt   = same_sign ? run_len + 1'b1 : CW'(1);
  assign fire      = upd && nonzero && (run_nxt == LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      run_len <= '0;
      run_neg <= 1'b0;
    end else if (upd) begin
      if (!nonzero || fire) run_len <= '0;
      else                  run_len <= run_nxt;
      run_neg <= raw_neg;
    end
  end

endmodule

// File: rtl/pr4_timing_err_det.sv
module pr4_timing_err_det #(
  parameter int W        = 8,
  parameter int HANG_N   = 16,
  parameter int HANG_MAG = 32,
  parameter int FRAC     = 12,
  parameter int DIV_LO   = 6,
  parameter int DIV_HI   = 10,
  parameter int DSHIFT   = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic signed [W-1:0] sample,
  input  logic [1:0]          decision,
  input  logic                sfc,
  input  logic                gain_sel,
  input  logic [6:0]          damp_code,
  output logic                err_valid,
  output logic signed [W:0]   err,
  output logic                pump_up,
  output logic                pump_dn,
  output logic [W:0]          pump_mag
);

  localparam int DW = 7;
  localparam int MW = W + 1 + DW;
  localparam logic signed [W:0] KICK_P = (W+1)'(HANG_MAG);
  localparam logic signed [W:0] KICK_N = -KICK_P;

  // Named internal events, also observed by the checker.
  logic                win_ready;
  logic                acc;
  logic                tracking;
  logic                hang_fire;
  logic signed [W-1:0] x_mid;
  logic [1:0]          d_mid;
  logic [1:0]          d_old;
  logic signed [W:0]   raw;
  logic signed [W:0]   scaled;
  logic signed [W:0]   next_err;
  logic [W:0]          next_mag;
  logic [MW-1:0]       damp_prod;

  assign acc = in_valid && win_ready;

  ted_window #(.W(W)) u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .sample    (sample),
    .decision  (decision),
    .x_mid     (x_mid),
    .d_mid     (d_mid),
    .d_old     (d_old),
    .win_ready (win_ready)
  );

  ted_err_form #(.W(W)) u_err_form (
    .x_new (sample),
    .d_new (decision),
    .x_mid (x_mid),
    .d_mid (d_mid),
    .d_old (d_old),
    .raw   (raw)
  );

  ted_gain_scale #(
    .W(W), .FRAC(FRAC), .DIV_LO(DIV_LO), .DIV_HI(DIV_HI)
  ) u_gain (
    .raw      (raw),
    .gain_sel (gain_sel),
    .scaled   (scaled)
  );

  ted_hang_guard #(.HANG_N(HANG_N)) u_hang (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     (acc && !tracking),
    .clr     (tracking),
    .raw_pos (!raw[W] && (raw != '0)),
    .raw_neg (raw[W]),
    .fire    (hang_fire)
  );

  // Mode: acquisition until the sync-field strobe, then tracking.
  always_ff @(posedge clk) begin
    if (!rst_n)   tracking <= 1'b0;
    else if (sfc) tracking <= 1'b1;
  end

  always_comb begin
    if (!acc)          next_err = '0;
    else if (tracking) next_err = scaled;
    else if (hang_fire) next_err = raw[W] ? KICK_N : KICK_P;
    else               next_err = raw;
    next_mag  = next_err[W] ? (W+1)'(-next_err) : next_err;
    damp_prod = {{DW{1'b0}}, next_mag} * {{(W+1){1'b0}}, damp_code};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_valid <= 1'b0;
      err       <= '0;
      pump_up   <= 1'b0;
      pump_dn   <= 1'b0;
      pump_mag  <= '0;
    end else begin
      err_valid <= acc;
      err       <= next_err;
      pump_up   <= acc && !next_err[W] && (next_err != '0);
      pump_dn   <= acc && next_err[W];
      pump_mag  <= acc ? damp_prod[DSHIFT +: W+1] : '0;
    end
  end

endmodule

// File: rtl/pr4_timing_err_det_chk.sv
module pr4_timing_err_det_chk #(
  parameter int W        = 8,
  parameter int HANG_MAG = 32,
  parameter int DIV_LO   = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            sfc,
  input logic            win_ready,
  input logic            tracking,
  input logic            hang_fire,
  input logic            err_valid,
  input logic signed [W:0] err,
  input logic            pump_up,
  input logic            pump_dn
);

  localparam int TRK_MAX = (1 << W) / DIV_LO;

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && win_ready) |=> err_valid);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && win_ready) |=> (!err_valid && err == '0));

  a_r5_sfc_sets_track: assert property (@(posedge clk) disable iff (!rst_n)
    sfc |=> tracking);

  a_r5_track_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    tracking |=> tracking);

  a_r10_no_kick_in_track: assert property (@(posedge clk) disable iff (!rst_n)
    hang_fire |-> !tracking);

  a_r8_kick_magnitude: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && $past(hang_fire)) |-> (err == HANG_MAG || err == -HANG_MAG));

  a_r6_track_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && $past(tracking)) |-> (err <= TRK_MAX && err >= -TRK_MAX));

  a_r9_pump_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pump_up && pump_dn));

  a_r9_up_sign: assert property (@(posedge clk) disable iff (!rst_n)
    pump_up |-> (err_valid && err > 0));

  a_r9_dn_sign: assert property (@(posedge clk) disable iff (!rst_n)
    pump_dn |-> (err_valid && err < 0));

endmodule

bind pr4_timing_err_det pr4_timing_err_det_chk #(
  .W(W), .HANG_MAG(HANG_MAG), .DIV_LO(DIV_LO)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .sfc       (sfc),
  .win_ready (win_ready),
  .tracking  (tracking),
  .hang_fire (hang_fire),
  .err_valid (err_valid),
  .err       (err),
  .pump_up   (pump_up),
  .pump_dn   (pump_dn)
);

// File: tb/pr4_timing_err_det_tb.sv
module pr4_timing_err_det_tb;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                in_valid = 1'b0;
  logic signed [W-1:0] sample = '0;
  logic [1:0]          decision = 2'b00;
  logic                sfc = 1'b0;
  logic                gain_sel = 1'b0;
  logic [6:0]          damp_code = '0;
  logic                err_valid;
  logic signed [W:0]   err;
  logic                pump_up, pump_dn;
  logic [W:0]          pump_mag;

  int checks = 0;
  int fails  = 0;
  int unsigned seed = 32'h1234_5678;

  // Model state
  int m_x1, m_l1, m_l2, m_cnt, m_run, m_rneg;
  bit m_trk;

  always #(CLK_PERIOD/2) clk = ~clk;

  pr4_timing_err_det u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sample(sample),
    .decision(decision), .sfc(sfc), .gain_sel(gain_sel), .damp_code(damp_code),
    .err_valid(err_valid), .err(err), .pump_up(pump_up), .pump_dn(pump_dn),
    .pump_mag(pump_mag)
  );

  function automatic int lvl(input logic [1:0] d);
    if (d == 2'b01) return 1;
    if (d == 2'b11) return -1;
    return 0;
  endfunction

  function automatic int absv(input int v);
    return v < 0 ? -v : v;
  endfunction

  function automatic int unsigned rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed >> 8;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_x1 = 0; m_l1 = 0; m_l2 = 0; m_cnt = 0; m_run = 0; m_rneg = 0; m_trk = 0;
  endtask

  // Called at a falling edge; drives one cycle and checks at the next falling edge.
  task automatic step(input int x, input logic [1:0] d, input bit v,
                      input bit s, input bit g, input logic [6:0] dc);
    int raw, e, ln, ev, emag;
    string tag;
    in_valid = v; sample = W'(x); decision = d; sfc = s; gain_sel = g; damp_code = dc;
    ev = 0; e = 0; tag = "R2";
    ln = lvl(d);
    if (v && m_cnt == 2) begin
      ev = 1;
      if (m_l1 == 0) begin
        raw = (ln > m_l2) ? m_x1 : (ln < m_l2) ? -m_x1 : 0;
        tag = "R3 R7";
      end else begin
        raw = (ln == m_l1) ? absv(x) - absv(m_x1) : 0;
        tag = "R4 R7";
      end
      if (m_trk) begin
        e = raw / (g ? 10 : 6);   // integer division truncates toward zero
        tag = "R6 R10";
        m_run = 0;
      end else begin
        e = raw;
        if (s) tag = "R5";
        if (raw == 0) m_run = 0;
        else begin
          if (m_run > 0 && m_rneg == (raw < 0)) m_run++;
          else m_run = 1;
          m_rneg = (raw < 0);
          if (m_run == 16) begin
            e = (raw < 0) ? -32 : 32;
            m_run = 0;
            tag = "R8";
          end
        end
      end
    end
    if (v) begin
      m_l2 = m_l1; m_l1 = ln; m_x1 = x;
      if (m_cnt < 2) m_cnt++;
    end
    if (s) m_trk = 1;
    @(negedge clk);
    emag = ev ? (absv(e) * int'(dc)) / 64 : 0;
    check(err_valid == ev[0], {tag, " valid"}, err_valid, ev);
    check(int'(err) == e, tag, int'(err), e);
    check(pump_up == (ev != 0 && e > 0), "R9 up", pump_up, ev != 0 && e > 0);
    check(pump_dn == (ev != 0 && e < 0), "R9 dn", pump_dn, ev != 0 && e < 0);
    check(int'(pump_mag) == emag, "R9 mag", int'(pump_mag), emag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; sfc = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs idle during reset
    check(!err_valid && err == '0, "R1 err", int'(err), 0);
    check(!pump_up && !pump_dn && pump_mag == '0, "R1 pump", int'(pump_mag), 0);
    rst_n = 1'b1;
    model_reset();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    model_reset();
    do_reset();
    step(0, 2'b00, 0, 0, 0, 7'd0);       // R1: first cycle after reset idle

    // R2: warm-up and idle gaps keep the window intact
    step(10, 2'b01, 1, 0, 0, 7'd64);
    step(0, 2'b00, 0, 0, 0, 7'd64);
    step(20, 2'b01, 1, 0, 0, 7'd64);
    step(0, 2'b00, 0, 0, 0, 7'd64);
    step(0, 2'b00, 0, 0, 0, 7'd64);
    step(-30, 2'b11, 1, 0, 0, 7'd64);
    step(40, 2'b01, 1, 0, 0, 7'd127);

    // R3 R7: full sweep of the zero-middle rule in acquisition, both trends
    for (int x = -128; x < 128; x++) begin
      step(5, 2'b11, 1, 0, 0, 7'(x + 128));
      step(x, 2'b00, 1, 0, 0, 7'(x + 128));
      step(7, 2'b01, 1, 0, 0, 7'(x + 128));
      step(9, 2'b01, 1, 0, 0, 7'd3);
      step(x, 2'b10, 1, 0, 0, 7'd99);
      step(-2, 2'b11, 1, 0, 0, 7'd99);
    end

    // R8: sixteen rising-magnitude ones in a row, then a zero break
    do_reset();
    for (int i = 1; i <= 20; i++) step(i, 2'b01, 1, 0, 0, 7'd100);
    step(0, 2'b00, 1, 0, 0, 7'd100);
    for (int i = 1; i <= 17; i++) step(-i, 2'b11, 1, 0, 0, 7'd100);
    // R8: falling magnitudes give negative runs
    for (int i = 0; i < 40; i++) step(100 - i, 2'b01, 1, 0, 0, 7'd50);
    // R8: run of 15 broken by a zero error, then a fresh run
    do_reset();
    for (int i = 1; i <= 17; i++) step(i, 2'b01, 1, 0, 0, 7'd10);
    step(17, 2'b01, 1, 0, 0, 7'd10);
    for (int i = 18; i <= 40; i++) step(i, 2'b01, 1, 0, 0, 7'd10);

    // Random acquisition traffic
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      int unsigned r = rnd();
      step(int'($signed(8'(r))), 2'(r >> 8), (r[19:16] != 0), 0, 0, 7'(r >> 20));
    end

    // R5 R6 R10: strobe with a sample, then tracking sweeps at both gains
    for (int g = 0; g < 2; g++) begin
      do_reset();
      step(10, 2'b01, 1, 0, 0, 7'd1);
      step(20, 2'b01, 1, 0, 0, 7'd1);
      step(60, 2'b01, 1, 1, g[0], 7'd1);
      step(61, 2'b01, 1, 0, g[0], 7'd1);
      for (int i = 0; i < 30; i++) step(62 + i, 2'b01, 1, 0, g[0], 7'd127);
      for (int x = -128; x < 128; x++) begin
        step(5, 2'b11, 1, 0, g[0], 7'd127);
        step(x, 2'b00, 1, 0, g[0], 7'd127);
        step(7, 2'b01, 1, 0, g[0], 7'd127);
        step(x, 2'b01, 1, 0, g[0], 7'd127);
        step(-3, 2'b00, 1, 0, g[0], 7'd127);
        step(11, 2'b11, 1, 0, g[0], 7'd127);
      end
      for (int i = 0; i < 1500; i++) begin
        int unsigned r = rnd();
        step(int'($signed(8'(r))), 2'(r >> 8), (r[19:16] != 0), r[21], r[22], 7'(r >> 23));
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule